// File: doc/BRIEF.md
# Reconfigurable Region Switch Controller

This controller looks after a single partially reconfigurable region that hosts a streaming hardware task. It sits on the stream between an upstream producer and the region. It also sits on the stream between the region and the downstream consumer. A processor programs it through a small AXI4-Lite register window, which holds:

- the run enable;
- the identity of the next task;
- a free-form task parameter word;
- the length of the region reset;
- an interrupt enable.

When software requests a task swap, the controller first lets the frame that is currently entering the region finish. It then refuses all further input. Next it waits until every beat already inside the region has come out. Only after that does it ask the external configuration machinery to load the new task, and during the load it hides the region's output. Once the load is reported complete, the controller holds the region in reset for a programmable number of cycles (never fewer than four). It then reopens the stream by itself. A sticky completion flag, and an optional interrupt, tell software that the swap is over.

Top module: `region_swap_ctrl`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0: the state field in bits [2:0] is 0 (idle). In this condition up_ready, region_rst, cfg_req and irq are all low. The reset-length register (offset 0x0C) reads 4.
- R2: Each register returns the value last written, with an OKAY response. The registers are: the parameter word at 0x08, which also appears on task_param; the reset length at 0x0C, bits [15:0]; the interrupt enable at 0x10, bit 0.
- R3: The control word is at 0x00: bit 0 is the enable, bit 1 is the swap request (write-only), and bits [15:8] hold the next task ID. Once the enable is set, the state goes to 1 (running). In that state every input beat reaches the task, and every task result appears on dn_valid/dn_data in order.
- R4: A swap request that arrives while a frame is partly accepted moves the state to 2 (waiting for frame end). The rest of that frame, up to and including the beat with up_last, is still accepted. After that, up_ready stays low.
- R5: After input stops, the state is 3 (draining). cfg_req is raised only once every beat accepted by the task has returned on its output.
- R6: While cfg_req or region_rst is high, up_ready is low and dn_valid stays low even when task_out_valid is high.
- R7: After cfg_done is sampled high, region_rst is high for exactly max(L, 4) consecutive cycles, where L is the reset-length register.
- R8: When region_rst falls, the state returns to 1 (running) and the stream flows again with no further register write. The loaded task ID appears in status bits [15:8].
- R9: Status bit 4 is set when a swap completes and stays set until software writes 1 to it. irq equals this bit ANDed with the interrupt enable.
- R10: A swap request written while the enable is 0 is held. It is served as soon as the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_awaddr | input | ADDR_W | Write address (byte) |
| csr_awvalid | input | 1 | Write address valid |
| csr_awready | output | 1 | Write address ready |
| csr_wdata | input | 32 | Write data |
| csr_wvalid | input | 1 | Write data valid |
| csr_wready | output | 1 | Write data ready |
| csr_bresp | output | 2 | Write response (always OKAY) |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response ready |
| csr_araddr | input | ADDR_W | Read address (byte) |
| csr_arvalid | input | 1 | Read address valid |
| csr_arready | output | 1 | Read address ready |
| csr_rdata | output | 32 | Read data |
| csr_rresp | output | 2 | Read response (always OKAY) |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data ready |
| up_valid | input | 1 | Upstream beat valid |
| up_ready | output | 1 | Upstream beat accepted |
| up_data | input | DATA_W | Upstream beat data |
| up_last | input | 1 | Upstream beat ends a frame |
| task_in_valid | output | 1 | Beat valid toward the region |
| task_in_ready | input | 1 | Region can take a beat |
| task_in_data | output | DATA_W | Beat data toward the region |
| task_out_valid | input | 1 | Region result valid |
| task_out_data | input | DATA_W | Region result data |
| dn_valid | output | 1 | Downstream result valid |
| dn_data | output | DATA_W | Downstream result data |
| cfg_req | output | 1 | Region load requested |
| cfg_id | output | 8 | Task ID to load |
| cfg_done | input | 1 | Region load finished |
| region_rst | output | 1 | Reset applied to the region |
| task_param | output | 32 | Task parameter word |
| irq | output | 1 | Swap-complete interrupt |

## Verification
The hardest case is a swap request that lands while a frame is only half accepted and the region still holds results in flight. The stimulus stops the stream after two beats of a frame and issues the request. It confirms the waiting state through the status register and then feeds the remaining beats. A three-stage task model in the bench keeps results in flight, so the draining state is really exercised, and cfg_req is checked against an empty scoreboard. During load and reset the model injects spurious task results to prove that the output is masked. The reset pulse is measured both below and above the four-cycle floor.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUN        = 3'd1,
        ST_WAIT_FRAME = 3'd2,
        ST_DRAIN      = 3'd3,
        ST_RECONFIG   = 3'd4,
        ST_RESET      = 3'd5
    } sw_state_e;

    localparam int TASK_ID_W  = 8;
    localparam int RST_MIN    = 4;

    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_PARAM  = 'h08;
    localparam int OFF_RSTLEN = 'h0C;
    localparam int OFF_IRQEN  = 'h10;

    typedef struct packed {
        logic                 enable;
        logic [TASK_ID_W-1:0] next_id;
    } ctrl_s;

    function automatic logic input_open(sw_state_e s, logic frame_open);
        return (s == ST_RUN) || (s == ST_WAIT_FRAME && frame_open);
    endfunction

    function automatic logic output_open(sw_state_e s);
        return (s == ST_RUN) || (s == ST_WAIT_FRAME) || (s == ST_DRAIN);
    endfunction

endpackage

// File: rtl/rsc_csr.sv
module rsc_csr
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LEN_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    awaddr,
    input  logic                 awvalid,
    output logic                 awready,
    input  logic [31:0]          wdata,
    input  logic                 wvalid,
    output logic                 wready,
    output logic [1:0]           bresp,
    output logic                 bvalid,
    input  logic                 bready,
    input  logic [ADDR_W-1:0]    araddr,
    input  logic                 arvalid,
    output logic                 arready,
    output logic [31:0]          rdata,
    output logic [1:0]           rresp,
    output logic                 rvalid,
    input  logic                 rready,
    input  sw_state_e            state,
    input  logic                 done,
    input  logic [TASK_ID_W-1:0] loaded_id,
    output ctrl_s                ctrl,
    output logic                 req_pulse,
    output logic                 clr_done,
    output logic [31:0]          param,
    output logic [LEN_W-1:0]     rst_len,
    output logic                 irq_en
);
    logic wr_fire, rd_fire;
    logic [31:0] rd_word;

    assign wr_fire = awvalid && wvalid && !bvalid;
    assign rd_fire = arvalid && !rvalid;
    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign arready = rd_fire;
    assign bresp   = 2'b00;
    assign rresp   = 2'b00;

    assign req_pulse = wr_fire && awaddr == ADDR_W'(OFF_CTRL) && wdata[1];
    assign clr_done  = wr_fire && awaddr == ADDR_W'(OFF_STATUS) && wdata[4];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            param   <= '0;
            rst_len <= LEN_W'(RST_MIN);
            irq_en  <= 1'b0;
            bvalid  <= 1'b0;
        end else begin
            if (wr_fire) begin
                bvalid <= 1'b1;
                if (awaddr == ADDR_W'(OFF_CTRL)) begin
                    ctrl.enable  <= wdata[0];
                    ctrl.next_id <= wdata[15:8];
                end
                if (awaddr == ADDR_W'(OFF_PARAM))  param   <= wdata;
                if (awaddr == ADDR_W'(OFF_RSTLEN)) rst_len <= wdata[LEN_W-1:0];
                if (awaddr == ADDR_W'(OFF_IRQEN))  irq_en  <= wdata[0];
            end else if (bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (araddr)
            ADDR_W'(OFF_CTRL):   rd_word = {16'h0, ctrl.next_id, 7'b0, ctrl.enable};
            ADDR_W'(OFF_STATUS): rd_word = {16'h0, loaded_id, 3'b0, done, 1'b0, state};
            ADDR_W'(OFF_PARAM):  rd_word = param;
            ADDR_W'(OFF_RSTLEN): rd_word = {{(32-LEN_W){1'b0}}, rst_len};
            ADDR_W'(OFF_IRQEN):  rd_word = {31'h0, irq_en};
            default:             rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    // R2
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);

endmodule

// File: rtl/rsc_flow_gate.sv
module rsc_flow_gate
    import rsc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  sw_state_e state,
    input  logic      up_valid,
    input  logic      up_last,
    output logic      up_ready,
    output logic      task_in_valid,
    input  logic      task_in_ready,
    input  logic      task_out_valid,
    output logic      dn_valid,
    output logic      frame_open,
    output logic      inflight_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic in_en, acc, ret;
    logic [CNT_W-1:0] inflight;

    assign in_en         = input_open(state, frame_open);
    assign up_ready      = in_en && task_in_ready;
    assign task_in_valid = in_en && up_valid;
    assign dn_valid      = output_open(state) && task_out_valid;
    assign acc           = up_valid && up_ready;
    assign ret           = dn_valid;
    assign inflight_zero = (inflight == '0);

    always_ff @(posedge clk) begin
        if (rst) frame_open <= 1'b0;
        else if (acc) frame_open <= !up_last;
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_RESET) begin
            inflight <= '0;
        end else begin
            case ({acc, ret})
                2'b10: if (inflight != CNT_MAX) inflight <= inflight + 1'b1;
                2'b01: if (inflight != '0) inflight <= inflight - 1'b1;
                default: ;
            endcase
        end
    end

    // R4
    frame_stop_chk: assert property (@(posedge clk) disable iff (rst)
        acc && up_last && state == ST_WAIT_FRAME |=> !up_ready);

endmodule

// File: rtl/rsc_switch_fsm.sv
module rsc_switch_fsm
    import rsc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ctrl_s                ctrl,
    input  logic                 req_pulse,
    input  logic                 clr_done,
    input  logic [LEN_W-1:0]     rst_len,
    input  logic                 frame_open,
    input  logic                 inflight_zero,
    input  logic                 cfg_done,
    output sw_state_e            state,
    output logic                 done,
    output logic                 pend,
    output logic [TASK_ID_W-1:0] loaded_id,
    output logic [TASK_ID_W-1:0] target_id,
    output logic                 region_rst
);
    logic [LEN_W-1:0] eff_len, rst_cnt;
    logic finish;

    assign eff_len    = (rst_len < LEN_W'(RST_MIN)) ? LEN_W'(RST_MIN) : rst_len;
    assign region_rst = (state == ST_RESET);
    assign finish     = (state == ST_RESET) && (rst_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rst_cnt   <= '0;
            loaded_id <= '0;
            target_id <= '0;
        end else begin
            case (state)
                ST_IDLE:       if (ctrl.enable) state <= ST_RUN;
                ST_RUN:        if (pend) begin
                                   state     <= ST_WAIT_FRAME;
                                   target_id <= ctrl.next_id;
                               end
                ST_WAIT_FRAME: if (!frame_open) state <= ST_DRAIN;
                ST_DRAIN:      if (inflight_zero) state <= ST_RECONFIG;
                ST_RECONFIG:   if (cfg_done) begin
                                   state     <= ST_RESET;
                                   rst_cnt   <= eff_len - 1'b1;
                                   loaded_id <= target_id;
                               end
                ST_RESET:      if (rst_cnt == '0) state <= ST_RUN;
                               else rst_cnt <= rst_cnt - 1'b1;
                default:       state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            done <= 1'b0;
        end else begin
            pend <= (pend && !finish) || req_pulse;
            if (finish) done <= 1'b1;
            else if (clr_done) done <= 1'b0;
        end
    end

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pend && state != ST_RESET |=> pend);
    // R7
    rst_floor_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(region_rst) |=> region_rst ##1 region_rst ##1 region_rst);
    // R9
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state) == ST_RESET);

endmodule

// File: rtl/region_swap_ctrl.sv
module region_swap_ctrl
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    csr_awaddr,
    input  logic                 csr_awvalid,
    output logic                 csr_awready,
    input  logic [31:0]          csr_wdata,
    input  logic                 csr_wvalid,
    output logic                 csr_wready,
    output logic [1:0]           csr_bresp,
    output logic                 csr_bvalid,
    input  logic                 csr_bready,
    input  logic [ADDR_W-1:0]    csr_araddr,
    input  logic                 csr_arvalid,
    output logic                 csr_arready,
    output logic [31:0]          csr_rdata,
    output logic [1:0]           csr_rresp,
    output logic                 csr_rvalid,
    input  logic                 csr_rready,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic [DATA_W-1:0]    up_data,
    input  logic                 up_last,
    output logic                 task_in_valid,
    input  logic                 task_in_ready,
    output logic [DATA_W-1:0]    task_in_data,
    input  logic                 task_out_valid,
    input  logic [DATA_W-1:0]    task_out_data,
    output logic                 dn_valid,
    output logic [DATA_W-1:0]    dn_data,
    output logic                 cfg_req,
    output logic [TASK_ID_W-1:0] cfg_id,
    input  logic                 cfg_done,
    output logic                 region_rst,
    output logic [31:0]          task_param,
    output logic                 irq
);
    sw_state_e              state;
    ctrl_s                  ctrl;
    logic                   req_pulse, clr_done, done, pend, irq_en;
    logic                   frame_open, inflight_zero;
    logic [LEN_W-1:0]       rst_len;
    logic [TASK_ID_W-1:0]   loaded_id;

    assign task_in_data = up_data;
    assign dn_data      = task_out_data;
    assign cfg_req      = (state == ST_RECONFIG);
    assign irq          = done && irq_en;

    rsc_csr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_csr (
        .clk(clk), .rst(rst),
        .awaddr(csr_awaddr), .awvalid(csr_awvalid), .awready(csr_awready),
        .wdata(csr_wdata), .wvalid(csr_wvalid), .wready(csr_wready),
        .bresp(csr_bresp), .bvalid(csr_bvalid), .bready(csr_bready),
        .araddr(csr_araddr), .arvalid(csr_arvalid), .arready(csr_arready),
        .rdata(csr_rdata), .rresp(csr_rresp), .rvalid(csr_rvalid), .rready(csr_rready),
        .state(state), .done(done), .loaded_id(loaded_id),
        .ctrl(ctrl), .req_pulse(req_pulse), .clr_done(clr_done),
        .param(task_param), .rst_len(rst_len), .irq_en(irq_en)
    );

    rsc_flow_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst(rst), .state(state),
        .up_valid(up_valid), .up_last(up_last), .up_ready(up_ready),
        .task_in_valid(task_in_valid), .task_in_ready(task_in_ready),
        .task_out_valid(task_out_valid), .dn_valid(dn_valid),
        .frame_open(frame_open), .inflight_zero(inflight_zero)
    );

    rsc_switch_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst(rst), .ctrl(ctrl), .req_pulse(req_pulse),
        .clr_done(clr_done), .rst_len(rst_len), .frame_open(frame_open),
        .inflight_zero(inflight_zero), .cfg_done(cfg_done),
        .state(state), .done(done), .pend(pend), .loaded_id(loaded_id),
        .target_id(cfg_id), .region_rst(region_rst)
    );

    // R5
    drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req) |-> inflight_zero && !frame_open);
    // R6
    iso_path_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_req || region_rst) |-> !dn_valid && !up_ready);
    // R8
    auto_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(region_rst) |-> state == ST_RUN && !pend);

endmodule

// File: tb/region_swap_ctrl_bench.sv
module region_swap_ctrl_bench;
    localparam int AW = 5;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic up_valid = 0, up_last = 0, task_in_ready = 1, cfg_done = 0, garbage = 0;
    logic [DW-1:0] up_data = '0;
    logic up_ready, task_in_valid, dn_valid, cfg_req, region_rst, irq;
    logic [DW-1:0] task_in_data, dn_data, task_out_data;
    logic task_out_valid;
    logic [7:0] cfg_id;
    logic [31:0] task_param;

    logic [2:0] pv;
    logic [DW-1:0] pd0, pd1, pd2;
    always @(posedge clk) begin
        if (rst) pv <= '0;
        else pv <= {pv[1:0], task_in_valid && task_in_ready};
        pd0 <= task_in_data; pd1 <= pd0; pd2 <= pd1;
    end
    assign task_out_valid = pv[2] || garbage;
    assign task_out_data  = pd2 ^ 16'hA5A5;

    region_swap_ctrl u_region_swap_ctrl (
        .clk(clk), .rst(rst),
        .csr_awaddr(awaddr), .csr_awvalid(awvalid), .csr_awready(awready),
        .csr_wdata(wdata), .csr_wvalid(wvalid), .csr_wready(wready),
        .csr_bresp(bresp), .csr_bvalid(bvalid), .csr_bready(bready),
        .csr_araddr(araddr), .csr_arvalid(arvalid), .csr_arready(arready),
        .csr_rdata(rdata), .csr_rresp(rresp), .csr_rvalid(rvalid), .csr_rready(rready),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data), .up_last(up_last),
        .task_in_valid(task_in_valid), .task_in_ready(task_in_ready), .task_in_data(task_in_data),
        .task_out_valid(task_out_valid), .task_out_data(task_out_data),
        .dn_valid(dn_valid), .dn_data(dn_data),
        .cfg_req(cfg_req), .cfg_id(cfg_id), .cfg_done(cfg_done),
        .region_rst(region_rst), .task_param(task_param), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit reported = 0;
    logic [DW-1:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    endtask

    // scoreboard monitor: R3 / R8 ordering and content
    always @(negedge clk) begin
        if (!rst && dn_valid) begin
            if (exp_q.size() == 0) chk(0, "R3 unexpected output", dn_data, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(dn_data == e, "R3 output data", dn_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        chk(bvalid && bresp == 2'b00, "R2 write response", {bvalid, bresp}, 3'b100);
        bready = 1;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        @(negedge clk);
        arvalid = 0;
        d = rdata;
        chk(rvalid && rresp == 2'b00, "R2 read response", {rvalid, rresp}, 3'b100);
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic send_beat(input logic [DW-1:0] d, input logic last);
        @(negedge clk);
        up_valid = 1; up_data = d; up_last = last;
        while (!up_ready) @(negedge clk);
        exp_q.push_back(d ^ 16'hA5A5);
        @(negedge clk);
        up_valid = 0; up_last = 0;
    endtask

    task automatic wait_cfg_req();
        while (!cfg_req) @(negedge clk);
    endtask

    // pulse cfg_done and measure region_rst; returns high-cycle count
    task automatic do_load(output int n, input string tag);
        @(negedge clk);
        cfg_done = 1;
        @(negedge clk);
        cfg_done = 0;
        n = 0;
        garbage = 1; #1;
        chk(region_rst && !dn_valid, {tag, " R6 reset isolation"}, dn_valid, 0);
        garbage = 0;
        while (region_rst && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        up_valid = 1; #1;
        chk(!up_ready && !region_rst && !cfg_req && !irq, "R1 idle outputs",
            {up_ready, region_rst, cfg_req, irq}, 0);
        up_valid = 0;
        rd(5'h04, d); chk(d == 0, "R1 status", d, 0);
        rd(5'h0C, d); chk(d == 4, "R1 reset length", d, 4);

        wr(5'h08, 32'hCAFE1234);
        rd(5'h08, d); chk(d == 32'hCAFE1234, "R2 param", d, 32'hCAFE1234);
        chk(task_param == 32'hCAFE1234, "R2 param pin", task_param, 32'hCAFE1234);
        wr(5'h0C, 32'd2);
        rd(5'h0C, d); chk(d == 2, "R2 reset length", d, 2);
        rd(5'h10, d); chk(d == 0, "R2 irq enable", d, 0);

        // R10: request while disabled is held
        wr(5'h00, 32'h0000_0702);
        repeat (4) @(negedge clk);
        rd(5'h04, d); chk(d[2:0] == 0, "R10 held in idle", d[2:0], 0);
        chk(!cfg_req, "R10 no load while idle", cfg_req, 0);
        wr(5'h00, 32'h0000_0701);
        wait_cfg_req();
        chk(cfg_id == 8'h07, "R10 served id", cfg_id, 7);
        do_load(n, "first");
        chk(n == 4, "R7 clamped reset length", n, 4);
        rd(5'h04, d);
        chk(d[2:0] == 1 && d[15:8] == 8'h07, "R8 running with loaded id", d[15:0], 16'h0711);
        chk(d[4] == 1, "R9 done set", d[4], 1);
        chk(!irq, "R9 irq masked", irq, 0);
        wr(5'h10, 32'h1);
        @(negedge clk); chk(irq, "R9 irq enabled", irq, 1);
        wr(5'h04, 32'h10);
        @(negedge clk); chk(!irq, "R9 irq cleared", irq, 0);
        rd(5'h04, d); chk(d[4] == 0, "R9 done cleared", d[4], 0);

        // R3: plain streaming
        for (int i = 0; i < 4; i++) send_beat(16'h1000 + 16'(i), i == 3);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);

        // R4/R5/R6/R7/R8: swap mid-frame
        wr(5'h0C, 32'd6);
        send_beat(16'h2000, 0);
        send_beat(16'h2001, 0);
        wr(5'h00, 32'h0000_0903);
        rd(5'h04, d); chk(d[2:0] == 2, "R4 waiting for frame end", d[2:0], 2);
        send_beat(16'h2002, 0);
        send_beat(16'h2003, 0);
        send_beat(16'h2004, 1);
        up_valid = 1; up_data = 16'hDEAD; #1;
        chk(!up_ready, "R4 input stopped after last", up_ready, 0);
        wait_cfg_req();
        chk(pv == 0 && exp_q.size() == 0, "R5 drained before load", exp_q.size(), 0);
        garbage = 1; #1;
        chk(!dn_valid && !up_ready, "R6 load isolation", {dn_valid, up_ready}, 0);
        garbage = 0;
        up_valid = 0;
        do_load(n, "second");
        chk(n == 6, "R7 programmed reset length", n, 6);
        rd(5'h04, d);
        chk(d[2:0] == 1 && d[15:8] == 8'h09, "R8 auto start id", d[15:0], 16'h0911);
        for (int i = 0; i < 3; i++) send_beat(16'h3000 + 16'(i), i == 2);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R8 stream flows after swap", exp_q.size(), 0);
        report();
    end
endmodule